// File: doc/BRIEF.md
# Multi-Channel Interrupt Vector Aggregator

This block gathers single-cycle event pulses from up to twelve data channels into two 32-bit interrupt status words. Each channel reports five kinds of event. Each event sets a sticky bit at a fixed position. The block raises one interrupt request line while any bit in either word is pending.

The host services the interrupt by reading a status word through a simple read port. The read returns the word as it stood before the read. In the same clock edge, the read clears that word, so each event is reported exactly once. A configured channel count masks out channels that are not in use.

Top module: `irqVecAggregator`

## Requirements
- R1: Within a channel's five-bit field, the events sit from the lowest bit upward in this order: device-to-host new transaction (+0), device-to-host list consumed (+1), device-to-host transaction done (+2), host-to-device list consumed (+3), host-to-device transaction done (+4).
- R2: Channel c maps to status word c/6, with its field starting at bit 5*(c mod 6). Channels 0 to 5 go to `vecLo` and channels 6 to 11 go to `vecHi`.
- R3: Bits 31 and 30 of both status words always read as zero.
- R4: A channel whose index is not below `chanCount` never sets a bit. Counts above 12 enable all twelve channels.
- R5: A set bit stays set on every later cycle until a read of its own word clears it.
- R6: A read with `rdEn` high clears the word chosen by `rdSel` (0 selects `vecLo`, 1 selects `vecHi`) at that clock edge. The other word is unaffected.
- R7: An event pulse sampled on the same edge as a clearing read of its word leaves its bit set after the read.
- R8: After a read edge, `rdData` holds the selected word's value from before that edge, and it keeps that value until the next read.
- R9: `irq` is high exactly in the cycles in which either status word has any bit set. It falls on the edge that leaves both words empty.
- R10: While reset is applied, and after it is released, both words, `rdData` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanCount | input | 4 | Number of active channels |
| evtD2hNew | input | 12 | Per-channel pulse: new device-to-host transaction |
| evtD2hListDone | input | 12 | Per-channel pulse: device-to-host list consumed |
| evtD2hXferDone | input | 12 | Per-channel pulse: device-to-host transaction done |
| evtH2dListDone | input | 12 | Per-channel pulse: host-to-device list consumed |
| evtH2dXferDone | input | 12 | Per-channel pulse: host-to-device transaction done |
| rdEn | input | 1 | Host read strobe (reads and clears) |
| rdSel | input | 1 | Word select for the read |
| rdData | output | 32 | Value of the word read, valid after the read edge |
| vecLo | output | 32 | Status word for channels 0 to 5 |
| vecHi | output | 32 | Status word for channels 6 to 11 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rdEn` and `rdSel` are driven to known values on every clock edge. They also assume that event inputs are plain one-cycle levels with no further protocol. Any pattern of pulses is therefore legal, including several pulses for one channel, or a pulse landing on a read.

The stimulus drives all inputs on the falling edge. It mixes sparse random pulses, random reads of either word and occasional random channel counts from 0 to 15 with directed cases for field order, masking and read collisions.

// File: rtl/irqVecPkg.sv
package irqVecPkg;

  // Position of each event kind inside a channel's field
  typedef enum logic [2:0] {
    EVT_D2H_NEW  = 3'd0,
    EVT_D2H_LIST = 3'd1,
    EVT_D2H_DONE = 3'd2,
    EVT_H2D_LIST = 3'd3,
    EVT_H2D_DONE = 3'd4
  } evtKind_e;

  localparam int EVT_KINDS = 5;
  localparam int NUM_WORDS = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] clearVec;
    logic                 rdLatch;
    logic                 rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqVecCtrl.sv
module irqVecCtrl
  import irqVecPkg::*;
#(
  parameter int NUM_CHAN = 12,
  parameter int CNT_W    = 4
) (
  input  logic [CNT_W-1:0]    chanCount,
  input  logic                rdEn,
  input  logic                rdSel,
  output ctrlStrobe_t         strobe,
  output logic [NUM_CHAN-1:0] chanEn
);

  always_comb begin
    strobe.rdLatch     = rdEn;
    strobe.rdSel       = rdSel;
    strobe.clearVec[0] = rdEn & ~rdSel;
    strobe.clearVec[1] = rdEn & rdSel;
  end

  // A channel is live when its index is below the configured count
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_en
    assign chanEn[c] = (chanCount > CNT_W'(c));
  end

endmodule

// File: rtl/irqVecDatapath.sv
module irqVecDatapath
  import irqVecPkg::*;
#(
  parameter int NUM_CHAN     = 12,
  parameter int CHAN_PER_VEC = 6,
  parameter int VEC_W        = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [NUM_CHAN-1:0]           chanEn,
  input  logic [NUM_CHAN*EVT_KINDS-1:0] evtFlat,
  output logic [VEC_W-1:0]              vecLo,
  output logic [VEC_W-1:0]              vecHi,
  output logic [VEC_W-1:0]              rdData,
  output logic                          irq
);

  localparam int USED_BITS = CHAN_PER_VEC * EVT_KINDS;

  logic [NUM_WORDS-1:0][VEC_W-1:0] setBits;
  logic [NUM_WORDS-1:0][VEC_W-1:0] vecReg;
  logic [NUM_WORDS-1:0][VEC_W-1:0] vecNext;

  // Pack masked channel events into their word slots
  for (genvar v = 0; v < NUM_WORDS; v++) begin : g_word
    for (genvar i = 0; i < CHAN_PER_VEC; i++) begin : g_slot
      if (v * CHAN_PER_VEC + i < NUM_CHAN) begin : g_live
        assign setBits[v][i*EVT_KINDS +: EVT_KINDS] =
          evtFlat[(v*CHAN_PER_VEC+i)*EVT_KINDS +: EVT_KINDS] &
          {EVT_KINDS{chanEn[v*CHAN_PER_VEC+i]}};
      end else begin : g_absent
        assign setBits[v][i*EVT_KINDS +: EVT_KINDS] = '0;
      end
    end
    if (USED_BITS < VEC_W) begin : g_pad
      assign setBits[v][VEC_W-1:USED_BITS] = '0;
    end

    // Clear on read, but a new event wins over the clear
    assign vecNext[v] = (strobe.clearVec[v] ? '0 : vecReg[v]) | setBits[v];

    always_ff @(posedge clk) begin
      if (!rstN) vecReg[v] <= '0;
      else       vecReg[v] <= vecNext[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irq    <= 1'b0;
    end else begin
      if (strobe.rdLatch) rdData <= strobe.rdSel ? vecReg[1] : vecReg[0];
      irq <= |vecNext;
    end
  end

  assign vecLo = vecReg[0];
  assign vecHi = vecReg[1];

  // R3: reserved top bits stay zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vecLo[VEC_W-1:USED_BITS] == '0) && (vecHi[VEC_W-1:USED_BITS] == '0));

  // R5: without a clear, no bit of a word falls
  assert_sticky_lo_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearVec[0] |=> ((vecLo & $past(vecLo)) == $past(vecLo)));
  assert_sticky_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearVec[1] |=> ((vecHi & $past(vecHi)) == $past(vecHi)));

  // R7: events that collide with a clear survive it
  assert_no_lost_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearVec[0] |=> ((vecLo & $past(setBits[0])) == $past(setBits[0])));

  // R8: read data is the pre-clear word
  assert_read_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdLatch |=> (rdData == $past(strobe.rdSel ? vecHi : vecLo)));

  // R9: request follows pending bits
  assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((vecLo != '0) || (vecHi != '0)));

endmodule

// File: rtl/irqVecAggregator.sv
module irqVecAggregator
  import irqVecPkg::*;
#(
  parameter int NUM_CHAN     = 12,
  parameter int CHAN_PER_VEC = 6,
  parameter int VEC_W        = 32,
  parameter int CNT_W        = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    chanCount,
  input  logic [NUM_CHAN-1:0] evtD2hNew,
  input  logic [NUM_CHAN-1:0] evtD2hListDone,
  input  logic [NUM_CHAN-1:0] evtD2hXferDone,
  input  logic [NUM_CHAN-1:0] evtH2dListDone,
  input  logic [NUM_CHAN-1:0] evtH2dXferDone,
  input  logic                rdEn,
  input  logic                rdSel,
  output logic [VEC_W-1:0]    rdData,
  output logic [VEC_W-1:0]    vecLo,
  output logic [VEC_W-1:0]    vecHi,
  output logic                irq
);

  ctrlStrobe_t                   strobe;
  logic [NUM_CHAN-1:0]           chanEn;
  logic [NUM_CHAN*EVT_KINDS-1:0] evtFlat;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_flat
    assign evtFlat[c*EVT_KINDS + int'(EVT_D2H_NEW)]  = evtD2hNew[c];
    assign evtFlat[c*EVT_KINDS + int'(EVT_D2H_LIST)] = evtD2hListDone[c];
    assign evtFlat[c*EVT_KINDS + int'(EVT_D2H_DONE)] = evtD2hXferDone[c];
    assign evtFlat[c*EVT_KINDS + int'(EVT_H2D_LIST)] = evtH2dListDone[c];
    assign evtFlat[c*EVT_KINDS + int'(EVT_H2D_DONE)] = evtH2dXferDone[c];
  end

  irqVecCtrl #(.NUM_CHAN(NUM_CHAN), .CNT_W(CNT_W)) uCtrl (
    .chanCount(chanCount),
    .rdEn     (rdEn),
    .rdSel    (rdSel),
    .strobe   (strobe),
    .chanEn   (chanEn)
  );

  irqVecDatapath #(.NUM_CHAN(NUM_CHAN), .CHAN_PER_VEC(CHAN_PER_VEC), .VEC_W(VEC_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .chanEn (chanEn),
    .evtFlat(evtFlat),
    .vecLo  (vecLo),
    .vecHi  (vecHi),
    .rdData (rdData),
    .irq    (irq)
  );

  // R4: channel count masks events of unused channels
  assert_masked_channel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chanCount == '0) |=> ((vecLo & ~$past(vecLo)) == '0) && ((vecHi & ~$past(vecHi)) == '0));

endmodule

// File: tb/tb_irqVecAggregator.sv
module tb_irqVecAggregator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chanCount = 4'd12;
  logic [11:0] ev [5];
  logic        rdEn = 1'b0, rdSel = 1'b0;
  logic [31:0] rdData, vecLo, vecHi;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] expVec [2];
  logic [31:0] expRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqVecAggregator dut (
    .clk(clk), .rstN(rstN), .chanCount(chanCount),
    .evtD2hNew(ev[0]), .evtD2hListDone(ev[1]), .evtD2hXferDone(ev[2]),
    .evtH2dListDone(ev[3]), .evtH2dXferDone(ev[4]),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData),
    .vecLo(vecLo), .vecHi(vecHi), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // Bits a word should gain from the current event inputs
  function automatic logic [31:0] expSet(int v, int cnt);
    logic [31:0] r = '0;
    for (int i = 0; i < 6; i++) begin
      int ch = v * 6 + i;
      if (ch < cnt)
        for (int k = 0; k < 5; k++)
          if (ev[k][ch]) r[5*i+k] = 1'b1;
    end
    return r;
  endfunction

  task automatic clearEv();
    for (int k = 0; k < 5; k++) ev[k] = '0;
  endtask

  // One cycle: inputs already set at a falling edge; model, clock, compare
  task automatic step(string req, bit rd, bit sel);
    logic [31:0] nxt [2];
    rdEn = rd; rdSel = sel;
    for (int v = 0; v < 2; v++)
      nxt[v] = ((rd && sel == v[0]) ? 32'h0 : expVec[v]) | expSet(v, int'(chanCount));
    if (rd) expRd = expVec[sel];
    @(posedge clk);
    @(negedge clk);
    expVec[0] = nxt[0]; expVec[1] = nxt[1];
    clearEv(); rdEn = 1'b0;
    chk(req, "vecLo", vecLo, expVec[0]);
    chk(req, "vecHi", vecHi, expVec[1]);
    chk(req, "irq", {31'b0, irq}, {31'b0, (expVec[0] != 0) || (expVec[1] != 0)});
    chk(req, "rdData", rdData, expRd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    clearEv();
    expVec[0] = '0; expVec[1] = '0; expRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "vecLo", vecLo, 0); chk("R10", "vecHi", vecHi, 0);
    chk("R10", "irq", {31'b0, irq}, 0); chk("R10", "rdData", rdData, 0);

    // R1: each event kind at its own offset in channel 0
    for (int k = 0; k < 5; k++) begin
      ev[k][0] = 1'b1;
      step("R1", 1'b0, 1'b0);
      chk("R1", "kind bit", vecLo, (32'h1 << (k + 1)) - 1);
    end
    step("R6", 1'b1, 1'b0);
    chk("R8", "read returns old", rdData, 32'h1F);

    // R2: channel 7 kind 3 and channel 5 kind 4
    ev[3][7] = 1'b1; ev[4][5] = 1'b1;
    step("R2", 1'b0, 1'b0);
    chk("R2", "ch7 pos", vecHi, 32'h1 << 8);
    chk("R2", "ch5 pos", vecLo, 32'h1 << 29);

    // R3: all events on all channels leave bits 30,31 clear
    for (int k = 0; k < 5; k++) ev[k] = '1;
    step("R3", 1'b0, 1'b0);
    chk("R3", "full lo", vecLo, 32'h3FFF_FFFF);
    chk("R3", "full hi", vecHi, 32'h3FFF_FFFF);

    // R5: sticky over idle cycles
    repeat (3) step("R5", 1'b0, 1'b0);
    // R6: read lo clears only lo; R9: irq stays for hi
    step("R6", 1'b1, 1'b0);
    chk("R6", "lo cleared", vecLo, 0);
    chk("R9", "irq with hi pending", {31'b0, irq}, 1);
    step("R9", 1'b1, 1'b1);
    chk("R9", "irq dropped", {31'b0, irq}, 0);
    chk("R8", "hi read value", rdData, 32'h3FFF_FFFF);

    // R4: count 3 masks channels 3..11; count 15 enables all
    chanCount = 4'd3;
    for (int k = 0; k < 5; k++) ev[k] = '1;
    step("R4", 1'b0, 1'b0);
    chk("R4", "count3 lo", vecLo, 32'h7FFF);
    chk("R4", "count3 hi", vecHi, 0);
    step("R4", 1'b1, 1'b0);
    chanCount = 4'd15;
    ev[0][11] = 1'b1;
    step("R4", 1'b0, 1'b0);
    chk("R4", "count15 ch11", vecHi, 32'h1 << 25);
    step("R4", 1'b1, 1'b1);
    chanCount = 4'd0;
    for (int k = 0; k < 5; k++) ev[k] = '1;
    step("R4", 1'b0, 1'b0);
    chk("R4", "count0", vecLo | vecHi, 0);
    chanCount = 4'd12;

    // R7: pulse on the clearing edge survives
    ev[0][0] = 1'b1;
    step("R7", 1'b0, 1'b0);
    ev[0][0] = 1'b1; ev[2][1] = 1'b1;
    step("R7", 1'b1, 1'b0);
    chk("R7", "collision kept", vecLo, 32'h81);
    chk("R7", "read pre-clear", rdData, 32'h1);

    // Random mix of pulses, reads and counts (R5 R6 R7 R8 R9)
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) chanCount = 4'($urandom_range(0, 15));
      for (int k = 0; k < 5; k++)
        ev[k] = 12'($urandom & $urandom & $urandom & $urandom);
      step("R6", ($urandom % 4) == 0, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule